// File: doc/BRIEF.md
# Panel Power Sequencing Controller

This block switches a flat-panel display on and off in a safe order. When software asks for the panel, the block turns on the panel supply first. It then enables the pixel clock and data lanes, and turns on the backlight last. When the request is withdrawn, the same three enables drop in the reverse order. Each gap between two steps has its own programmable delay. All delays are counted in whole periods of an external millisecond tick strobe. A single shared down-counter times every gap.

After the panel supply has been switched off, the block enforces a minimum off time before the supply may come up again. A request that arrives during this lockout is held and is served as soon as the lockout ends. Reset places the block in the same lockout, with all enables low, so the off-time rule also covers a fresh start. If the request is withdrawn part-way through power-up, the block turns back from wherever it is and follows the power-down order. Once power-down has begun, it always runs to the end. Two status outputs report when the panel is fully on and when it is fully off and ready for a new power-up.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `vdd_en`, `lane_en`, `bl_en`, `full_on` and `ready_off` are all low. After reset, `vdd_en` cannot rise until at least `RESET_WAIT` ticks have passed.
- R2: With `on_req` held high, `lane_en` rises exactly `dly_rise + dly_settle` ticks after `vdd_en` rises. The counter holds its value on cycles that carry no tick.
- R3: With `on_req` held high, `bl_en` rises exactly `dly_bl_on` ticks after `lane_en` rises. `full_on` is high together with `bl_en`.
- R4: When `on_req` falls while the panel is fully on, `bl_en` and `full_on` drop on the next clock edge while `lane_en` stays high. `lane_en` then drops exactly `dly_bl_off` ticks later.
- R5: `vdd_en` drops exactly `dly_vdd_off` ticks after `lane_en` drops.
- R6: `vdd_en` cannot rise again until `dly_cycle` ticks have passed since it fell. If `on_req` is already high when the lockout ends, `vdd_en` rises exactly `dly_cycle` ticks after it fell.
- R7: If `on_req` falls before the backlight has come on, `lane_en` drops on the next edge if it was high, and `bl_en` never rises. `vdd_en` then drops `dly_vdd_off` ticks after that edge.
- R8: Once power-down has started, raising `on_req` again has no effect. The lanes and supply still drop on schedule, and the full lockout still applies before `vdd_en` rises again.
- R9: A delay value of zero moves the sequence to its next step on the very next clock edge.
- R10: `full_on` is high only while all three enables are high. `ready_off` is high only when all enables are low and the lockout has ended. `ready_off` rises exactly `dly_cycle` ticks after `vdd_en` falls when `on_req` is low.
- R11: `lane_en` is never high without `vdd_en`, and `bl_en` is never high without `lane_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle strobe that marks one delay unit (nominally 1 ms) |
| on_req | input | 1 | High requests the panel on; low requests it off |
| dly_rise | input | DLY_W | Supply rise time, in ticks |
| dly_settle | input | DLY_W | Supply-stable to lanes-on gap, in ticks (added to `dly_rise`) |
| dly_bl_on | input | DLY_W | Lanes-on to backlight-on gap, in ticks |
| dly_bl_off | input | DLY_W | Backlight-off to lanes-off gap, in ticks |
| dly_vdd_off | input | DLY_W | Lanes-off to supply-off gap, in ticks |
| dly_cycle | input | DLY_W | Minimum supply off time before a new power-up, in ticks |
| vdd_en | output | 1 | Panel supply enable |
| lane_en | output | 1 | Clock and data lane enable |
| bl_en | output | 1 | Backlight enable |
| full_on | output | 1 | Panel fully on |
| ready_off | output | 1 | Panel fully off and lockout ended |

## Verification
The assertions check the ordering rules on every cycle. Lanes and backlight stay nested inside the supply, each rising edge needs its predecessor already high, and each falling edge needs its successor already low. A tick counter in the checker shows that the supply never comes back up before the off time has passed. The status outputs are also checked against the enables on every cycle. The exact tick counts of each gap, a request held through the lockout, the two abort points during power-up, the request ignored during power-down and the one-cycle advance on zero delays can only be shown by the bench's directed scenarios.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_OFF           = 3'd0,
    ST_CYCLE_WAIT    = 3'd1,
    ST_VDD_WAIT      = 3'd2,
    ST_LANE_WAIT     = 3'd3,
    ST_FULL_ON       = 3'd4,
    ST_BL_OFF_WAIT   = 3'd5,
    ST_LANE_OFF_WAIT = 3'd6
  } pps_state_e;

  // Selects which programmed gap is loaded into the shared timer.
  typedef enum logic [2:0] {
    LD_UP_LANES = 3'd0,
    LD_UP_BL    = 3'd1,
    LD_DN_LANES = 3'd2,
    LD_DN_VDD   = 3'd3,
    LD_CYCLE    = 3'd4
  } pps_load_e;

endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_n_sync = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pps_delay_timer.sv
module pps_delay_timer #(
  parameter int CNT_W     = 11,
  parameter int RESET_VAL = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RESET_VAL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Load has priority; otherwise step down once per tick, stopping at zero.
  always_comb begin
    cnt_en = load | (tick & (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_CNT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pps_seq_fsm.sv
module pps_seq_fsm
  import pps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      on_req,
  input  logic      timer_done,
  output logic      load,
  output pps_load_e load_sel,
  output logic      vdd_en,
  output logic      lane_en,
  output logic      bl_en,
  output logic      full_on,
  output logic      ready_off
);

  pps_state_e state_q;
  pps_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_sel = LD_CYCLE;
    unique case (state_q)
      ST_CYCLE_WAIT: begin
        if (timer_done) state_d = ST_OFF;
      end
      ST_OFF: begin
        if (on_req) begin
          state_d  = ST_VDD_WAIT;
          load     = 1'b1;
          load_sel = LD_UP_LANES;
        end
      end
      ST_VDD_WAIT: begin
        if (!on_req) begin
          state_d  = ST_LANE_OFF_WAIT;
          load     = 1'b1;
          load_sel = LD_DN_VDD;
        end else if (timer_done) begin
          state_d  = ST_LANE_WAIT;
          load     = 1'b1;
          load_sel = LD_UP_BL;
        end
      end
      ST_LANE_WAIT: begin
        if (!on_req) begin
          state_d  = ST_LANE_OFF_WAIT;
          load     = 1'b1;
          load_sel = LD_DN_VDD;
        end else if (timer_done) begin
          state_d = ST_FULL_ON;
        end
      end
      ST_FULL_ON: begin
        if (!on_req) begin
          state_d  = ST_BL_OFF_WAIT;
          load     = 1'b1;
          load_sel = LD_DN_LANES;
        end
      end
      ST_BL_OFF_WAIT: begin
        if (timer_done) begin
          state_d  = ST_LANE_OFF_WAIT;
          load     = 1'b1;
          load_sel = LD_DN_VDD;
        end
      end
      ST_LANE_OFF_WAIT: begin
        if (timer_done) begin
          state_d  = ST_CYCLE_WAIT;
          load     = 1'b1;
          load_sel = LD_CYCLE;
        end
      end
      default: begin
        state_d  = ST_CYCLE_WAIT;
        load     = 1'b1;
        load_sel = LD_CYCLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CYCLE_WAIT;
    else        state_q <= state_d;
  end

  // Enables decode straight from the state register.
  always_comb begin
    vdd_en    = (state_q == ST_VDD_WAIT)  || (state_q == ST_LANE_WAIT) ||
                (state_q == ST_FULL_ON)   || (state_q == ST_BL_OFF_WAIT) ||
                (state_q == ST_LANE_OFF_WAIT);
    lane_en   = (state_q == ST_LANE_WAIT) || (state_q == ST_FULL_ON) ||
                (state_q == ST_BL_OFF_WAIT);
    bl_en     = (state_q == ST_FULL_ON);
    full_on   = (state_q == ST_FULL_ON);
    ready_off = (state_q == ST_OFF);
  end

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int DLY_W       = 10,
  parameter int RESET_WAIT  = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             on_req,
  input  logic [DLY_W-1:0] dly_rise,
  input  logic [DLY_W-1:0] dly_settle,
  input  logic [DLY_W-1:0] dly_bl_on,
  input  logic [DLY_W-1:0] dly_bl_off,
  input  logic [DLY_W-1:0] dly_vdd_off,
  input  logic [DLY_W-1:0] dly_cycle,
  output logic             vdd_en,
  output logic             lane_en,
  output logic             bl_en,
  output logic             full_on,
  output logic             ready_off
);

  // One spare bit holds the sum of the two power-up parts.
  localparam int CNT_W = DLY_W + 1;

  logic             rst_n_int;
  logic             timer_load;
  logic             timer_done;
  pps_load_e        load_sel;
  logic [CNT_W-1:0] load_val;

  pps_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    unique case (load_sel)
      LD_UP_LANES: load_val = CNT_W'(dly_rise) + CNT_W'(dly_settle);
      LD_UP_BL:    load_val = CNT_W'(dly_bl_on);
      LD_DN_LANES: load_val = CNT_W'(dly_bl_off);
      LD_DN_VDD:   load_val = CNT_W'(dly_vdd_off);
      default:     load_val = CNT_W'(dly_cycle);
    endcase
  end

  pps_delay_timer #(.CNT_W(CNT_W), .RESET_VAL(RESET_WAIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick     (tick),
    .load     (timer_load),
    .load_val (load_val),
    .done     (timer_done)
  );

  pps_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .on_req     (on_req),
    .timer_done (timer_done),
    .load       (timer_load),
    .load_sel   (load_sel),
    .vdd_en     (vdd_en),
    .lane_en    (lane_en),
    .bl_en      (bl_en),
    .full_on    (full_on),
    .ready_off  (ready_off)
  );

endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
  parameter int DLY_W      = 10,
  parameter int RESET_WAIT = 400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             on_req,
  input logic [DLY_W-1:0] dly_cycle,
  input logic             vdd_en,
  input logic             lane_en,
  input logic             bl_en,
  input logic             full_on,
  input logic             ready_off
);

  localparam int OW = DLY_W + 2;
  localparam logic [OW-1:0] OMAX = '1;

  // Ticks seen since the supply was last high, and the off time then owed.
  logic [OW-1:0] off_ticks;
  logic [OW-1:0] need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_ticks <= '0;
      need      <= OW'(RESET_WAIT);
    end else if (vdd_en) begin
      off_ticks <= '0;
      need      <= OW'(dly_cycle);
    end else if (tick && off_ticks != OMAX) begin
      off_ticks <= off_ticks + 1'b1;
    end
  end

  p_lane_in_vdd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en |-> vdd_en);
  p_bl_in_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |-> lane_en);
  p_lane_after_vdd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_en) |-> $past(vdd_en));
  p_bl_after_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(lane_en));
  p_lane_drop_bl_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lane_en) |-> $past(!bl_en));
  p_vdd_drop_lane_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_en) |-> $past(!lane_en));
  p_off_time_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdd_en) |-> off_ticks >= need);
  p_bl_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(on_req));
  p_full_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full_on |-> (vdd_en && lane_en && bl_en));
  p_ready_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_off |-> (!vdd_en && off_ticks >= need));

endmodule

bind panel_pwr_seq pps_chk #(.DLY_W(DLY_W), .RESET_WAIT(RESET_WAIT)) u_pps_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .on_req    (on_req),
  .dly_cycle (dly_cycle),
  .vdd_en    (vdd_en),
  .lane_en   (lane_en),
  .bl_en     (bl_en),
  .full_on   (full_on),
  .ready_off (ready_off)
);

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;

  localparam int DLY_W = 10;
  localparam int RWAIT = 20;
  localparam int LIMIT = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic on_req = 1'b0;
  logic [DLY_W-1:0] dly_rise = 10'd3, dly_settle = 10'd4, dly_bl_on = 10'd10;
  logic [DLY_W-1:0] dly_bl_off = 10'd5, dly_vdd_off = 10'd6, dly_cycle = 10'd12;
  logic vdd_en, lane_en, bl_en, full_on, ready_off;

  int errors = 0;
  int checks = 0;
  int ticks_cnt = 0;
  int cyc = 0;
  int div = 0;
  bit lane_seen = 0;
  bit bl_seen = 0;

  always #5 clk = ~clk;

  panel_pwr_seq #(.DLY_W(DLY_W), .RESET_WAIT(RWAIT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .on_req(on_req),
    .dly_rise(dly_rise), .dly_settle(dly_settle), .dly_bl_on(dly_bl_on),
    .dly_bl_off(dly_bl_off), .dly_vdd_off(dly_vdd_off), .dly_cycle(dly_cycle),
    .vdd_en(vdd_en), .lane_en(lane_en), .bl_en(bl_en),
    .full_on(full_on), .ready_off(ready_off)
  );

  // Tick every third cycle, driven away from the active edge.
  always @(negedge clk) begin
    tick <= (div == 2);
    div = (div == 2) ? 0 : div + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tick) ticks_cnt <= ticks_cnt + 1;
  end

  always @(negedge clk) begin
    if (lane_en) lane_seen = 1;
    if (bl_en)   bl_seen = 1;
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 60000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int idx);
    case (idx)
      0: return vdd_en;
      1: return lane_en;
      2: return bl_en;
      default: return ready_off;
    endcase
  endfunction

  task automatic wait_sig(input int idx, input logic val, input string req);
    int n = 0;
    while (sig(idx) !== val && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    check(sig(idx) === val, req, int'(sig(idx)), int'(val));
  endtask

  task automatic t_reset_lockout();
    int t0;
    rst_n = 1'b0;
    on_req = 1'b1;
    repeat (4) @(negedge clk);
    check({vdd_en, lane_en, bl_en, full_on, ready_off} == 5'b0, "R1 in reset",
          int'({vdd_en, lane_en, bl_en, full_on, ready_off}), 0);
    rst_n = 1'b1;
    t0 = ticks_cnt;
    @(negedge clk);
    check({vdd_en, lane_en, bl_en, full_on, ready_off} == 5'b0, "R1 after release",
          int'({vdd_en, lane_en, bl_en, full_on, ready_off}), 0);
    wait_sig(0, 1'b1, "R1 vdd rise");
    check((ticks_cnt - t0) >= RWAIT && (ticks_cnt - t0) <= RWAIT + 1,
          "R1 reset lockout ticks", ticks_cnt - t0, RWAIT);
  endtask

  task automatic t_power_up();
    int t0;
    t0 = ticks_cnt;
    wait_sig(1, 1'b1, "R2 lanes rise");
    check(ticks_cnt - t0 == 7, "R2 supply to lanes ticks", ticks_cnt - t0, 7);
    check(bl_en == 1'b0 && vdd_en == 1'b1, "R11 nesting at lanes on",
          int'({vdd_en, bl_en}), 2);
    t0 = ticks_cnt;
    wait_sig(2, 1'b1, "R3 backlight rise");
    check(ticks_cnt - t0 == 10, "R3 lanes to backlight ticks", ticks_cnt - t0, 10);
    check(full_on == 1'b1, "R3 full_on with backlight", int'(full_on), 1);
  endtask

  task automatic t_power_down();
    int t0;
    on_req = 1'b0;
    @(negedge clk);
    check({bl_en, full_on, lane_en, vdd_en} == 4'b0011, "R4 backlight drops first",
          int'({bl_en, full_on, lane_en, vdd_en}), 3);
    t0 = ticks_cnt;
    wait_sig(1, 1'b0, "R4 lanes fall");
    check(ticks_cnt - t0 == 5, "R4 backlight to lanes ticks", ticks_cnt - t0, 5);
    check(vdd_en == 1'b1, "R5 supply still on", int'(vdd_en), 1);
    t0 = ticks_cnt;
    wait_sig(0, 1'b0, "R5 supply fall");
    check(ticks_cnt - t0 == 6, "R5 lanes to supply ticks", ticks_cnt - t0, 6);
    check(ready_off == 1'b0, "R10 not ready during lockout", int'(ready_off), 0);
    t0 = ticks_cnt;
    wait_sig(3, 1'b1, "R10 ready rise");
    check(ticks_cnt - t0 == 12, "R10 lockout ticks to ready", ticks_cnt - t0, 12);
    on_req = 1'b1;
    @(negedge clk);
    check(vdd_en == 1'b1 && ready_off == 1'b0, "R6 request served when ready",
          int'({vdd_en, ready_off}), 2);
  endtask

  task automatic t_abort_late();
    int t0;
    lane_seen = 0;
    wait_sig(1, 1'b1, "R7 lanes rise before abort");
    bl_seen = 0;
    on_req = 1'b0;
    @(negedge clk);
    check(lane_en == 1'b0 && vdd_en == 1'b1, "R7 lanes drop on abort",
          int'({lane_en, vdd_en}), 1);
    t0 = ticks_cnt;
    wait_sig(0, 1'b0, "R7 supply fall");
    check(ticks_cnt - t0 == 6, "R7 late abort supply ticks", ticks_cnt - t0, 6);
    check(bl_seen == 0, "R7 backlight never on (late)", int'(bl_seen), 0);
    wait_sig(3, 1'b1, "R7 ready after late abort");
  endtask

  task automatic t_abort_early();
    int t0;
    on_req = 1'b1;
    wait_sig(0, 1'b1, "R7 supply rise");
    lane_seen = 0;
    bl_seen = 0;
    @(negedge clk);
    on_req = 1'b0;
    @(negedge clk);
    t0 = ticks_cnt;
    wait_sig(0, 1'b0, "R7 supply fall early");
    check(ticks_cnt - t0 == 6, "R7 early abort supply ticks", ticks_cnt - t0, 6);
    check({lane_seen, bl_seen} == 2'b00, "R7 lanes and backlight never on (early)",
          int'({lane_seen, bl_seen}), 0);
    wait_sig(3, 1'b1, "R7 ready after early abort");
  endtask

  task automatic t_ignore_in_down();
    int t0;
    on_req = 1'b1;
    wait_sig(2, 1'b1, "R8 full on");
    on_req = 1'b0;
    @(negedge clk);
    t0 = ticks_cnt;
    on_req = 1'b1;
    bl_seen = 0;
    @(negedge clk);
    check(bl_en == 1'b0 && lane_en == 1'b1, "R8 backlight stays off",
          int'({bl_en, lane_en}), 1);
    wait_sig(1, 1'b0, "R8 lanes fall");
    check(ticks_cnt - t0 == 5, "R8 lanes fall on schedule", ticks_cnt - t0, 5);
    t0 = ticks_cnt;
    wait_sig(0, 1'b0, "R8 supply fall");
    check(ticks_cnt - t0 == 6, "R8 supply falls on schedule", ticks_cnt - t0, 6);
    t0 = ticks_cnt;
    wait_sig(0, 1'b1, "R6 held request served");
    check(ticks_cnt - t0 == 12, "R6 early request waits lockout", ticks_cnt - t0, 12);
    check(bl_seen == 0, "R8 backlight off through down", int'(bl_seen), 0);
  endtask

  task automatic t_zero_delay();
    int c0;
    wait_sig(2, 1'b1, "R9 full on");
    dly_bl_off = '0;
    dly_vdd_off = '0;
    on_req = 1'b0;
    @(negedge clk);
    check(bl_en == 1'b0 && lane_en == 1'b1, "R9 backlight off", int'({bl_en, lane_en}), 1);
    c0 = cyc;
    wait_sig(1, 1'b0, "R9 lanes fall");
    check(cyc - c0 == 1, "R9 zero gap backlight to lanes cycles", cyc - c0, 1);
    c0 = cyc;
    wait_sig(0, 1'b0, "R9 supply fall");
    check(cyc - c0 == 1, "R9 zero gap lanes to supply cycles", cyc - c0, 1);
  endtask

  initial begin
    t_reset_lockout();
    t_power_up();
    t_power_down();
    t_abort_late();
    t_abort_early();
    t_ignore_in_down();
    t_zero_delay();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule